// File: doc/BRIEF.md
# Code Patch and Breakpoint Comparator Unit

This debug block watches the addresses of instruction fetches and literal (data) loads that fall in the low code region. Each address is compared with a small bank of programmable word-address comparators. Some comparators watch instruction fetches and the rest watch literal loads. When a comparator matches, the block does one of two things. It can redirect the access to an entry of a remap table held in RAM. It can instead raise a breakpoint flag on the lower halfword, the upper halfword or both halfwords of the fetched word.

Software programs the block through a plain register port. The control register sits at byte offset 0x00, the remap base at 0x04, and comparator i at 0x08 + 4*i. A write to the control register is accepted only when it carries a key bit. Matching needs both the global enable and the comparator's own enable.

The match outputs are combinational from the address input by default. A parameter adds one register stage on the outputs.

Top module: `code_patch_unit`

## Requirements
- R1: After reset the global enable and all comparator enables are 0, and the remap base and all comparator fields read 0. No match output is raised.
- R2: A write to the control register (offset 0x00) changes the global enable (bit 0) only if bit 1 of the written data is 1. Bit 1 always reads as 0.
- R3: Control bits 7:4 read as N_CODE, bits 11:8 read as N_LIT, and bits 13:12 read as 0. Writes do not change these fields.
- R4: The remap base register (offset 0x04) stores written bits 28:5. All of its other bits read as 0.
- R5: Comparator i (offset 0x08+4*i) stores the replace mode in bits 31:30, the match word address in bits 28:2 and the enable in bit 0. Bits 29 and 1 read as 0.
- R6: A comparator matches only when the global enable and its own enable are both 1, and its address bits 28:2 equal those of acc_addr.
- R7: For a fetch matched by a code comparator, the replace mode sets the result. Mode 0 raises remap_vld. Mode 1 raises bkpt_lo only. Mode 2 raises bkpt_hi only. Mode 3 raises both breakpoint flags. No breakpoint mode raises remap_vld.
- R8: When remap_vld is 1, remap_addr is {3'b001, base bits 28:5, winning index (3 bits), 2'b00}. When remap_vld is 0, remap_addr is 0.
- R9: An access whose address bits 31:29 are not all zero never matches.
- R10: Comparators 0..N_CODE-1 match only fetches (acc_is_lit=0). The remaining comparators match only literal loads (acc_is_lit=1) and always remap, whatever their mode field holds.
- R11: When several comparators match, the lowest-index comparator alone decides the outputs.
- R12: With REG_OUT=1 the outputs equal the combinational result one clock later, and they are 0 during reset.
- R13: While acc_valid is 0, no output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access address is valid |
| acc_addr | input | 32 | Fetch or load address |
| acc_is_lit | input | 1 | 1 for a literal load, 0 for an instruction fetch |
| remap_addr | output | 32 | Redirected address in the remap table |
| remap_vld | output | 1 | Access is redirected |
| bkpt_lo | output | 1 | Breakpoint on the lower halfword |
| bkpt_hi | output | 1 | Breakpoint on the upper halfword |

## Verification
The bench builds the default configuration of six code comparators and two literal comparators twice. One copy has combinational outputs (REG_OUT=0) and the other has registered outputs (REG_OUT=1). Both copies share one register port and one access port, so every probe checks the same result at zero and at one cycle of latency. With only eight comparators and four modes, the bench can sweep every comparator index against every mode and both access types. Each case also covers same-word offsets, neighbouring words and out-of-region addresses. Together these reach every entry of the remap table and every priority pairing the bench sets up.

// File: rtl/code_patch_pkg.sv
package code_patch_pkg;
   localparam int DATA_W    = 32;
   localparam int MADDR_LO  = 2;
   localparam int MADDR_HI  = 28;
   localparam int BASE_LO   = 5;
   localparam int REGION_LO = 29;
   localparam int OFF_W     = 6;
   localparam int IDX_W     = BASE_LO - MADDR_LO;
   localparam int MADDR_W   = MADDR_HI - MADDR_LO + 1;
   localparam int BASE_W    = MADDR_HI - BASE_LO + 1;

   typedef enum logic [1:0] {
      RPL_REMAP   = 2'd0,
      RPL_BP_LO   = 2'd1,
      RPL_BP_HI   = 2'd2,
      RPL_BP_BOTH = 2'd3
   } rpl_mode_e;

   typedef struct packed {
      rpl_mode_e            mode;
      logic [MADDR_W-1:0]   addr;
      logic                 en;
   } cmp_entry_t;
endpackage

// File: rtl/code_patch_regs.sv
module code_patch_regs
   import code_patch_pkg::*;
#(
   parameter int N_CODE = 6,
   parameter int N_LIT  = 2,
   localparam int NUM_CMP = N_CODE + N_LIT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [OFF_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   output logic                        glob_en,
   output logic [BASE_W-1:0]           remap_base,
   output cmp_entry_t [NUM_CMP-1:0]    cmp_tbl
);
   localparam int WIDX_W = OFF_W - 2;
   localparam int CTRL_IDX  = 0;
   localparam int REMAP_IDX = 1;
   localparam int CMP0_IDX  = 2;

   logic [WIDX_W-1:0] widx;
   logic              unused_low;
   assign widx       = reg_addr[OFF_W-1:2];
   assign unused_low = ^reg_addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en    <= 1'b0;
         remap_base <= '0;
         cmp_tbl    <= '0;
      end else if (reg_we) begin
         if (int'(widx) == CTRL_IDX && reg_wdata[1])
            glob_en <= reg_wdata[0];
         if (int'(widx) == REMAP_IDX)
            remap_base <= reg_wdata[MADDR_HI:BASE_LO];
         for (int i = 0; i < NUM_CMP; i++) begin
            if (int'(widx) == CMP0_IDX + i) begin
               cmp_tbl[i].mode <= rpl_mode_e'(reg_wdata[DATA_W-1:DATA_W-2]);
               cmp_tbl[i].addr <= reg_wdata[MADDR_HI:MADDR_LO];
               cmp_tbl[i].en   <= reg_wdata[0];
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (int'(widx) == CTRL_IDX) begin
         reg_rdata[0]     = glob_en;
         reg_rdata[7:4]   = 4'(N_CODE);
         reg_rdata[11:8]  = 4'(N_LIT);
         reg_rdata[13:12] = 2'b00;
      end else if (int'(widx) == REMAP_IDX) begin
         reg_rdata[MADDR_HI:BASE_LO] = remap_base;
      end
      for (int i = 0; i < NUM_CMP; i++) begin
         if (int'(widx) == CMP0_IDX + i) begin
            reg_rdata[DATA_W-1:DATA_W-2]  = cmp_tbl[i].mode;
            reg_rdata[MADDR_HI:MADDR_LO]  = cmp_tbl[i].addr;
            reg_rdata[0]                  = cmp_tbl[i].en;
         end
      end
   end

   AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(widx) == CTRL_IDX && !reg_wdata[1]) |=> $stable(glob_en)); // R2
endmodule

// File: rtl/code_patch_match.sv
module code_patch_match
   import code_patch_pkg::*;
#(
   parameter int N_CODE = 6,
   parameter int N_LIT  = 2,
   localparam int NUM_CMP = N_CODE + N_LIT
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_valid,
   input  logic [DATA_W-1:0]          acc_addr,
   input  logic                       acc_is_lit,
   input  logic                       glob_en,
   input  logic [BASE_W-1:0]          remap_base,
   input  cmp_entry_t [NUM_CMP-1:0]   cmp_tbl,
   output logic                       hit_remap,
   output logic                       hit_lo,
   output logic                       hit_hi,
   output logic [DATA_W-1:0]          hit_addr
);
   logic [NUM_CMP-1:0] hit;
   logic [NUM_CMP-1:0] win;
   logic               found;
   logic [IDX_W-1:0]   idx;
   logic               in_region;
   logic               unused_low;

   assign in_region  = (acc_addr[DATA_W-1:REGION_LO] == '0);
   assign unused_low = ^acc_addr[MADDR_LO-1:0];

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      localparam bit IS_LIT = (i >= N_CODE);
      assign hit[i] = acc_valid && glob_en && cmp_tbl[i].en && in_region
                      && (cmp_tbl[i].addr == acc_addr[MADDR_HI:MADDR_LO])
                      && (IS_LIT ? acc_is_lit : !acc_is_lit);
   end

   always_comb begin
      win   = '0;
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < NUM_CMP; i++) begin
         if (hit[i] && !found) begin
            win[i] = 1'b1;
            found  = 1'b1;
            idx    = IDX_W'(i);
         end
      end
   end

   always_comb begin
      hit_remap = 1'b0;
      hit_lo    = 1'b0;
      hit_hi    = 1'b0;
      hit_addr  = '0;
      if (found) begin
         if (int'(idx) >= N_CODE || cmp_tbl[idx].mode == RPL_REMAP) begin
            hit_remap = 1'b1;
            hit_addr  = {3'b001, remap_base, idx, 2'b00};
         end else begin
            hit_lo = (cmp_tbl[idx].mode == RPL_BP_LO) || (cmp_tbl[idx].mode == RPL_BP_BOTH);
            hit_hi = (cmp_tbl[idx].mode == RPL_BP_HI) || (cmp_tbl[idx].mode == RPL_BP_BOTH);
         end
      end
   end

   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |-> glob_en); // R6
   AST_BP_NO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_remap |-> !(hit_lo || hit_hi)); // R7
   AST_REMAP_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      hit_remap |-> (hit_addr[DATA_W-1:REGION_LO] == 3'b001)); // R8
   AST_REGION_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_remap || hit_lo || hit_hi) |-> in_region); // R9
   AST_LIT_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_is_lit && (hit_lo || hit_hi || hit_remap)) |-> hit_remap); // R10
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(hit_remap || hit_lo || hit_hi)); // R13
endmodule

// File: rtl/code_patch_unit.sv
module code_patch_unit
   import code_patch_pkg::*;
#(
   parameter int N_CODE  = 6,
   parameter int N_LIT   = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [5:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               acc_valid,
   input  logic [31:0]        acc_addr,
   input  logic               acc_is_lit,
   output logic [31:0]        remap_addr,
   output logic               remap_vld,
   output logic               bkpt_lo,
   output logic               bkpt_hi
);
   localparam int NUM_CMP = N_CODE + N_LIT;

   if (NUM_CMP > (1 << IDX_W)) begin : g_chk_tbl
      $error("comparator count exceeds remap table slots");
   end
   if (N_CODE < 1 || N_CODE > 15 || N_LIT > 15) begin : g_chk_cnt
      $error("comparator counts out of range for the control fields");
   end
   if (NUM_CMP + 2 > (1 << (OFF_W - 2))) begin : g_chk_map
      $error("register map does not fit the offset width");
   end

   logic                     glob_en;
   logic [BASE_W-1:0]        remap_base;
   cmp_entry_t [NUM_CMP-1:0] cmp_tbl;
   logic                     c_vld, c_lo, c_hi;
   logic [DATA_W-1:0]        c_addr;

   code_patch_regs #(.N_CODE(N_CODE), .N_LIT(N_LIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
      .remap_base(remap_base), .cmp_tbl(cmp_tbl)
   );

   code_patch_match #(.N_CODE(N_CODE), .N_LIT(N_LIT)) u_match (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_is_lit(acc_is_lit), .glob_en(glob_en), .remap_base(remap_base),
      .cmp_tbl(cmp_tbl), .hit_remap(c_vld), .hit_lo(c_lo), .hit_hi(c_hi),
      .hit_addr(c_addr)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            remap_vld  <= 1'b0;
            bkpt_lo    <= 1'b0;
            bkpt_hi    <= 1'b0;
            remap_addr <= '0;
         end else begin
            remap_vld  <= c_vld;
            bkpt_lo    <= c_lo;
            bkpt_hi    <= c_hi;
            remap_addr <= c_addr;
         end
      end
      AST_STAGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
         c_vld |=> remap_vld); // R12
      AST_STAGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         !c_vld |=> !remap_vld); // R12
   end else begin : g_comb
      assign remap_vld  = c_vld;
      assign bkpt_lo    = c_lo;
      assign bkpt_hi    = c_hi;
      assign remap_addr = c_addr;
   end
endmodule

// File: tb/code_patch_unit_test.sv
module code_patch_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata, rdata_q;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_is_lit = 1'b0;
   logic [31:0] ra, ra_q;
   logic        rv, rv_q, lo, lo_q, hi, hi_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench-side register image, from writes
   bit        m_gen;
   logic [31:0] m_base;
   logic [1:0]  m_mode [8];
   logic [26:0] m_addr [8];
   bit          m_en [8];

   always #5 clk = ~clk;

   code_patch_unit #(.N_CODE(6), .N_LIT(2), .REG_OUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_is_lit(acc_is_lit), .remap_addr(ra),
      .remap_vld(rv), .bkpt_lo(lo), .bkpt_hi(hi));

   code_patch_unit #(.N_CODE(6), .N_LIT(2), .REG_OUT(1'b1)) uut_q (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_q), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_is_lit(acc_is_lit), .remap_addr(ra_q),
      .remap_vld(rv_q), .bkpt_lo(lo_q), .bkpt_hi(hi_q));

   task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 6'h00 && d[1]) m_gen = d[0];
      if (a == 6'h04) m_base = d & 32'h1FFF_FFE0;
      if (a >= 6'h08 && a <= 6'h24) begin
         m_mode[(a-8)/4] = d[31:30];
         m_addr[(a-8)/4] = d[28:2];
         m_en[(a-8)/4]   = d[0];
      end
   endtask

   task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, {3'b0, rdata}, {3'b0, exp});
   endtask

   function automatic logic [34:0] model(input logic [31:0] a, input bit lit, input bit v);
      logic [34:0] r = '0;
      for (int i = 0; i < 8; i++) begin
         if (v && m_gen && m_en[i] && a[31:29] == 3'b000 && m_addr[i] == a[28:2]
             && ((i >= 6) == lit)) begin
            if (i >= 6 || m_mode[i] == 2'd0) begin
               r[34] = 1'b1;
               r[31:0] = 32'h2000_0000 + m_base + 32'(4 * i);
            end else begin
               r[33] = m_mode[i][0];
               r[32] = m_mode[i][1];
            end
            return r;
         end
      end
      return r;
   endfunction

   task automatic probe(input string req, input logic [31:0] a, input bit lit, input bit v);
      logic [34:0] e = model(a, lit, v);
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_is_lit = lit;
      #1;
      chk(req, {rv, lo, hi, ra}, e);
      @(posedge clk);
      #1;
      chk({req, " R12"}, {rv_q, lo_q, hi_q, ra_q}, e);
   endtask

   task automatic clear_cmps();
      for (int i = 0; i < 8; i++) wr(6'(8 + 4*i), 32'h0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      m_gen = 0; m_base = 0;
      for (int i = 0; i < 8; i++) begin m_mode[i] = 0; m_addr[i] = 0; m_en[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      chk("R12 reset", {rv_q, lo_q, hi_q, ra_q}, '0);
      rst_n = 1'b1;

      // R1 / R3 reset readback
      rd("R1 R3 ctrl", 6'h00, 32'h0000_0260);
      rd("R1 remap", 6'h04, 32'h0);
      for (int i = 0; i < 8; i++) rd("R1 cmp", 6'(8 + 4*i), 32'h0);
      probe("R1 idle", 32'h0, 1'b0, 1'b1);

      // R2 key guard
      wr(6'h00, 32'h0000_0001);
      rd("R2 no key", 6'h00, 32'h0000_0260);
      wr(6'h00, 32'hFFFF_FFFF);
      rd("R2 R3 keyed", 6'h00, 32'h0000_0261);
      wr(6'h00, 32'h0000_0002);
      rd("R2 disable", 6'h00, 32'h0000_0260);

      // R4 / R5 field layouts
      wr(6'h04, 32'hFFFF_FFFF);
      rd("R4 base mask", 6'h04, 32'h1FFF_FFE0);
      wr(6'h14, 32'hFFFF_FFFF);
      rd("R5 cmp layout", 6'h14, 32'hDFFF_FFFD);
      wr(6'h14, 32'h0);
      wr(6'h04, 32'h1234_5660);
      rd("R4 base", 6'h04, 32'h1234_5660);

      // R6 enables
      wr(6'h08, 32'h0000_0201);
      probe("R6 global off", 32'h200, 1'b0, 1'b1);
      wr(6'h00, 32'h3);
      probe("R6 both on", 32'h200, 1'b0, 1'b1);
      probe("R13 invalid", 32'h200, 1'b0, 1'b0);
      wr(6'h08, 32'h0000_0200);
      probe("R6 cmp off", 32'h200, 1'b0, 1'b1);

      // R7 R8 R9 R10 sweep over all comparators and modes
      for (int k = 0; k < 8; k++) begin
         for (int m = 0; m < 4; m++) begin
            logic [31:0] base_a = 32'h0000_1000 + 32'(k * 32'h40) + 32'(m * 32'h8);
            clear_cmps();
            wr(6'(8 + 4*k), {2'(m), 1'b0, base_a[28:2], 2'b01});
            probe("R7 R8 R10 fetch", base_a, 1'b0, 1'b1);
            probe("R7 R8 R10 load", base_a, 1'b1, 1'b1);
            probe("R6 same word", base_a + 32'd2, (k >= 6), 1'b1);
            probe("R6 next word", base_a + 32'd4, (k >= 6), 1'b1);
            probe("R9 region", base_a | 32'h2000_0000, (k >= 6), 1'b1);
            probe("R9 region top", base_a | 32'h8000_0000, (k >= 6), 1'b1);
         end
      end

      // R11 priority
      clear_cmps();
      wr(6'h0C, {2'd1, 1'b0, 27'h123, 2'b01});
      wr(6'h14, {2'd2, 1'b0, 27'h123, 2'b01});
      probe("R11 low wins", {3'b0, 27'h123, 2'b00}, 1'b0, 1'b1);
      wr(6'h0C, 32'h0);
      probe("R11 next", {3'b0, 27'h123, 2'b00}, 1'b0, 1'b1);
      wr(6'h20, {2'd3, 1'b0, 27'h77, 2'b01});
      wr(6'h24, {2'd0, 1'b0, 27'h77, 2'b01});
      probe("R11 R10 lit", {3'b0, 27'h77, 2'b00}, 1'b1, 1'b1);
      probe("R13 lit idle", {3'b0, 27'h77, 2'b00}, 1'b1, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule